// File: doc/BRIEF.md
# Interlocked Flash Control Register

This block holds the control state that steers program and erase operations on an on-chip flash array. Software reaches it through a small synchronous register bus. A chain of permission bits guards every control bit, so a mode can only be entered after the bits it depends on are already in place. The top bit of the control register is not written by software. It follows an active-low external write-protect pin, which passes through a synchronizer first.

Two erase-block-select registers sit beside the control register and share the same guard. Their bits pick the flash blocks that an erase will act on. The block decodes the stored bits into six mode lines for the flash array: erase-setup, program-setup, erase, program, erase-verify and program-verify. Clearing bits is always allowed, so software can back out of any state. Losing the hardware enable wipes everything.

Top module: `flashctl_top`

## Requirements
- R1: After a synchronous reset, control bits 6..0, every block-select bit, every mode output and `bus_rdata` are 0. The synchronizer starts in the protected state, so bit 7 is 0.
- R2: Control bit 7 (hardware enable) is read-only and reads 1 when `wp_n_i` is low and 0 when it is high. The pin passes through two flops, so a level change at the pin shows in bit 7 after two clock edges.
- R3: Writing 1 to control bit 6 (software enable) takes effect only while bit 7 is 1.
- R4: Control bits 5 (erase setup), 4 (program setup), 3 (erase verify) and 2 (program verify) can be set only if bit 6 was 1 before the write.
- R5: Control bit 1 (erase) can be set only if bits 6 and 5 were both 1 before the write. Control bit 0 (program) can be set only if bits 6 and 4 were both 1 before the write. A write that sets a bit together with its prerequisites sets only the prerequisites.
- R6: Writing 0 to any of control bits 6..0, or to any block-select bit, is always accepted.
- R7: When bit 6 becomes 0, bits 5..0 become 0 in the same update. When bit 5 becomes 0, bit 1 is cleared. When bit 4 becomes 0, bit 0 is cleared.
- R8: While bit 7 is 0, control bits 6..0 and all block-select bits are held at 0, and all mode outputs are 0.
- R9: Block-select bits, at addresses 1 and 2, can be set only if control bit 6 was 1 before the write.
- R10: Each mode output is 1 only when its control bit is set together with bits 7 and 6. Erase also requires bit 5, and program also requires bit 4.
- R11: `bus_rdata` is registered. It returns the register at the address presented one cycle earlier: the control register at address 0 and block-select at addresses 1 and 2. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n_i | input | 1 | Active-low external write-protect pin (asynchronous) |
| bus_addr | input | ADDR_W (2) | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| erase_setup_o | output | 1 | Erase setup state |
| prog_setup_o | output | 1 | Program setup state |
| erase_o | output | 1 | Erase mode |
| prog_o | output | 1 | Program mode |
| erase_verify_o | output | 1 | Erase-verify mode |
| prog_verify_o | output | 1 | Program-verify mode |
| blk_sel_o | output | NBLK*BLK_W (16) | Erase-block-select bits, register 0 in the low half |

## Verification
The assertions check the permission chain on every cycle. They confirm that no software-enable, setup, verify, erase, program or block-select bit rises unless its prerequisites held one cycle earlier. They also confirm that a cleared hardware enable leaves every stored bit at zero, that written zeros always stick, and that the synchronizer latency and read-data latency hold.

Some behaviour only the bench scenarios can show. These include a single write that carries a dependent bit together with its prerequisites, the clearing cascade after bit 6 or bit 5 is dropped, and the mapping of block-select addresses and unmapped addresses. The full protect-pin sequence, from enabled to protected with state wiped, is also scenario-only.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;
  localparam int DW     = 8;
  localparam int NCTRL  = 7;
  localparam int B_SWEN = 6;
  localparam int B_ESET = 5;
  localparam int B_PSET = 4;
  localparam int B_EVER = 3;
  localparam int B_PVER = 2;
  localparam int B_ERS  = 1;
  localparam int B_PRG  = 0;
endpackage

// File: rtl/flashctl_sync.sv
module flashctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  output logic hw_en_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], pin_n_i};
  end

  assign hw_en_o = ~chain_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      // R2: an enable change reflects the pin two edges earlier
      p_sync_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (hw_en_o != $past(hw_en_o)) |-> (hw_en_o == !$past(pin_n_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/flashctl_ctrl.sv
module flashctl_ctrl
  import flashctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_en,
  input  logic             wr_en,
  input  logic [NCTRL-1:0] wdata,
  output logic [NCTRL-1:0] bits_q
);
  logic [NCTRL-1:0] permit;
  logic [NCTRL-1:0] cand;
  logic [NCTRL-1:0] nxt;

  always_comb begin
    permit         = '0;
    permit[B_SWEN] = 1'b1;
    permit[B_ESET] = bits_q[B_SWEN];
    permit[B_PSET] = bits_q[B_SWEN];
    permit[B_EVER] = bits_q[B_SWEN];
    permit[B_PVER] = bits_q[B_SWEN];
    permit[B_ERS]  = bits_q[B_SWEN] & bits_q[B_ESET];
    permit[B_PRG]  = bits_q[B_SWEN] & bits_q[B_PSET];

    cand = wr_en ? (wdata & (bits_q | permit)) : bits_q;
    if (!cand[B_SWEN]) cand[B_ESET:0] = '0;
    if (!cand[B_ESET]) cand[B_ERS]    = 1'b0;
    if (!cand[B_PSET]) cand[B_PRG]    = 1'b0;

    nxt = hw_en ? cand : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else     bits_q <= nxt;
  end

  // R3
  p_swen_needs_hw_r3: assert property (@(posedge clk) disable iff (rst)
    (bits_q[B_SWEN] && !$past(bits_q[B_SWEN])) |-> $past(hw_en));
  // R4
  p_setup_needs_sw_r4: assert property (@(posedge clk) disable iff (rst)
    ((bits_q[B_ESET:B_PVER] & ~$past(bits_q[B_ESET:B_PVER])) != '0) |-> $past(bits_q[B_SWEN]));
  // R5
  p_erase_chain_r5: assert property (@(posedge clk) disable iff (rst)
    (bits_q[B_ERS] && !$past(bits_q[B_ERS])) |-> $past(bits_q[B_SWEN] && bits_q[B_ESET]));
  p_prog_chain_r5: assert property (@(posedge clk) disable iff (rst)
    (bits_q[B_PRG] && !$past(bits_q[B_PRG])) |-> $past(bits_q[B_SWEN] && bits_q[B_PSET]));
  // R6
  p_zero_accepted_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(wdata[B_SWEN])) |-> !bits_q[B_SWEN]);
  // R7
  p_swen_cascade_r7: assert property (@(posedge clk) disable iff (rst)
    (!bits_q[B_SWEN] && $past(bits_q[B_SWEN])) |-> (bits_q[B_ESET:0] == '0));
  // R8
  p_hw_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(hw_en) |-> (bits_q == '0));
endmodule

// File: rtl/flashctl_blk.sv
module flashctl_blk #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hw_en,
  input  logic         sw_en,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    if (!hw_en)     nxt = '0;
    else if (wr_en) nxt = wdata & (q | {W{sw_en}});
    else            nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R9
  p_blk_needs_sw_r9: assert property (@(posedge clk) disable iff (rst)
    ((q & ~$past(q)) != '0) |-> $past(sw_en));
  // R8
  p_blk_hw_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(hw_en) |-> (q == '0));
endmodule

// File: rtl/flashctl_top.sv
module flashctl_top
  import flashctl_pkg::*;
#(
  parameter int              ADDR_W    = 2,
  parameter int              BLK_W     = 8,
  parameter int              NBLK      = 2,
  parameter int              SYNC_STG  = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] BLK_BASE  = ADDR_W'(1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wp_n_i,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic                  erase_setup_o,
  output logic                  prog_setup_o,
  output logic                  erase_o,
  output logic                  prog_o,
  output logic                  erase_verify_o,
  output logic                  prog_verify_o,
  output logic [NBLK*BLK_W-1:0] blk_sel_o
);
  localparam int SEL_W = NBLK * BLK_W;

  logic             hw_en;
  logic [NCTRL-1:0] ctrl_bits;
  logic             ctrl_wr;
  logic [BLK_W-1:0] blk_q [NBLK];
  logic [DW-1:0]    rd_next;
  logic             sw_ok;

  initial begin
    assert (BLK_W <= DW);
  end

  flashctl_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_n_i (wp_n_i),
    .hw_en_o (hw_en)
  );

  assign ctrl_wr = bus_we && (bus_addr == CTRL_ADDR);

  flashctl_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .hw_en  (hw_en),
    .wr_en  (ctrl_wr),
    .wdata  (bus_wdata[NCTRL-1:0]),
    .bits_q (ctrl_bits)
  );

  generate
    for (genvar g = 0; g < NBLK; g++) begin : g_blk
      localparam logic [ADDR_W-1:0] MY_ADDR = BLK_BASE + ADDR_W'(g);
      logic blk_wr;
      assign blk_wr = bus_we && (bus_addr == MY_ADDR);
      flashctl_blk #(.W(BLK_W)) u_blk (
        .clk   (clk),
        .rst   (rst),
        .hw_en (hw_en),
        .sw_en (ctrl_bits[B_SWEN]),
        .wr_en (blk_wr),
        .wdata (bus_wdata[BLK_W-1:0]),
        .q     (blk_q[g])
      );
      assign blk_sel_o[g*BLK_W +: BLK_W] = blk_q[g];
    end
  endgenerate

  assign sw_ok          = hw_en & ctrl_bits[B_SWEN];
  assign erase_setup_o  = sw_ok & ctrl_bits[B_ESET];
  assign prog_setup_o   = sw_ok & ctrl_bits[B_PSET];
  assign erase_verify_o = sw_ok & ctrl_bits[B_EVER];
  assign prog_verify_o  = sw_ok & ctrl_bits[B_PVER];
  assign erase_o        = sw_ok & ctrl_bits[B_ESET] & ctrl_bits[B_ERS];
  assign prog_o         = sw_ok & ctrl_bits[B_PSET] & ctrl_bits[B_PRG];

  always_comb begin
    rd_next = '0;
    if (bus_addr == CTRL_ADDR) rd_next = {hw_en, ctrl_bits};
    for (int i = 0; i < NBLK; i++) begin
      if (bus_addr == BLK_BASE + ADDR_W'(i)) rd_next[BLK_W-1:0] = blk_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R10
  p_erase_decode_r10: assert property (@(posedge clk) disable iff (rst)
    erase_o |-> $past(ctrl_bits[B_ESET]));
  p_prog_decode_r10: assert property (@(posedge clk) disable iff (rst)
    prog_o |-> $past(ctrl_bits[B_PSET]));
  // R11
  p_read_latency_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == CTRL_ADDR) |-> (bus_rdata[DW-1] == $past(hw_en)));
  // R1
  p_sel_width_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (blk_sel_o == SEL_W'(0)));
endmodule

// File: tb/test_flashctl_top.sv
module test_flashctl_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wp_n = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       erase_setup_o, prog_setup_o, erase_o, prog_o, erase_verify_o, prog_verify_o;
  logic [15:0] blk_sel_o;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit running = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flashctl_top i_flashctl_top (
    .clk(clk), .rst(rst), .wp_n_i(wp_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .erase_setup_o(erase_setup_o), .prog_setup_o(prog_setup_o),
    .erase_o(erase_o), .prog_o(prog_o),
    .erase_verify_o(erase_verify_o), .prog_verify_o(prog_verify_o),
    .blk_sel_o(blk_sel_o)
  );

  // behavioural reference model
  logic [1:0] m_pipe;
  logic [6:0] m_c;
  logic [7:0] m_a, m_b, m_rd;
  logic [6:0] nc;
  logic [7:0] na, nb;
  logic       m_hw;

  function automatic bit allowed(int b, logic [6:0] cur);
    case (b)
      6:       return 1'b1;
      5, 4, 3, 2: return cur[6];
      1:       return cur[6] && cur[5];
      default: return cur[6] && cur[4];
    endcase
  endfunction

  always @(posedge clk) begin
    m_hw = !m_pipe[1];
    if (rst) begin
      m_pipe <= 2'b11; m_c <= '0; m_a <= '0; m_b <= '0; m_rd <= '0;
    end else begin
      m_pipe <= {m_pipe[0], wp_n};
      nc = m_c; na = m_a; nb = m_b;
      if (bus_we && bus_addr == 2'd0) begin
        for (int b = 0; b < 7; b++) begin
          if (!bus_wdata[b]) nc[b] = 1'b0;
          else if (allowed(b, m_c)) nc[b] = 1'b1;
        end
      end
      if (nc[6] == 1'b0) nc = '0;
      if (nc[5] == 1'b0) nc[1] = 1'b0;
      if (nc[4] == 1'b0) nc[0] = 1'b0;
      for (int b = 0; b < 8; b++) begin
        if (bus_we && bus_addr == 2'd1) na[b] = bus_wdata[b] && (m_a[b] || m_c[6]);
        if (bus_we && bus_addr == 2'd2) nb[b] = bus_wdata[b] && (m_b[b] || m_c[6]);
      end
      if (!m_hw) begin nc = '0; na = '0; nb = '0; end
      case (bus_addr)
        2'd0:    m_rd <= {m_hw, m_c};
        2'd1:    m_rd <= m_a;
        2'd2:    m_rd <= m_b;
        default: m_rd <= '0;
      endcase
      m_c <= nc; m_a <= na; m_b <= nb;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && !rst) begin
      automatic bit h = !m_pipe[1];
      automatic bit s = h && m_c[6];
      check("model rdata R11", {24'd0, bus_rdata}, {24'd0, m_rd});
      check("model blk R9", {16'd0, blk_sel_o}, {16'd0, m_b, m_a});
      check("model modes R10",
            {26'd0, erase_setup_o, prog_setup_o, erase_o, prog_o, erase_verify_o, prog_verify_o},
            {26'd0, s && m_c[5], s && m_c[4], s && m_c[5] && m_c[1], s && m_c[4] && m_c[0],
             s && m_c[3], s && m_c[2]});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(logic [1:0] a, logic [7:0] exp, string tag);
    bus_addr = a;
    @(negedge clk);
    check(tag, {24'd0, bus_rdata}, {24'd0, exp});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    running = 1'b1;
    check("R1 rdata after reset", {24'd0, bus_rdata}, 32'd0);
    rd_check(2'd0, 8'h00, "R1 ctrl after reset");
    rd_check(2'd1, 8'h00, "R1 blk after reset");
    wr(2'd0, 8'h40);
    rd_check(2'd0, 8'h00, "R3 swen blocked while protected");
    wp_n = 1'b0;
    idle(3);
    rd_check(2'd0, 8'h80, "R2 hw enable follows pin low");
    wr(2'd1, 8'hFF);
    rd_check(2'd1, 8'h00, "R9 blk set blocked without swen");
    wr(2'd0, 8'h7F);
    rd_check(2'd0, 8'hC0, "R4 R5 same-write dependents not set");
    wr(2'd1, 8'hA5);
    rd_check(2'd1, 8'hA5, "R9 blk A set with swen");
    wr(2'd2, 8'h3C);
    rd_check(2'd2, 8'h3C, "R9 blk B set with swen");
    rd_check(2'd3, 8'h00, "R11 unmapped address");
    check("R9 blk_sel_o", {16'd0, blk_sel_o}, 32'h3CA5);
    wr(2'd0, 8'h60);
    wr(2'd0, 8'h62);
    check("R10 erase mode", {29'd0, erase_setup_o, erase_o, prog_o}, 32'b110);
    rd_check(2'd0, 8'hE2, "R5 erase set after setup");
    wr(2'd0, 8'h43);
    rd_check(2'd0, 8'hC0, "R7 setup clear drops erase");
    wr(2'd0, 8'h50);
    wr(2'd0, 8'h5D);
    check("R10 program and verify modes",
          {28'd0, prog_o, prog_setup_o, erase_verify_o, prog_verify_o}, 32'hF);
    rd_check(2'd0, 8'hDD, "R4 setup verify bits");
    wr(2'd0, 8'h1D);
    rd_check(2'd0, 8'h80, "R7 swen clear drops all");
    check("R7 modes off", {26'd0, erase_setup_o, prog_setup_o, erase_o, prog_o,
          erase_verify_o, prog_verify_o}, 32'd0);
    wr(2'd1, 8'h00);
    rd_check(2'd1, 8'h00, "R6 blk zero accepted without swen");
    wr(2'd0, 8'h40);
    wr(2'd0, 8'h50);
    wr(2'd0, 8'h51);
    rd_check(2'd0, 8'hD1, "R5 program after program setup");
    wr(2'd0, 8'h00);
    rd_check(2'd0, 8'h80, "R6 zero write accepted");
    wr(2'd0, 8'h40);
    wr(2'd0, 8'h60);
    wr(2'd0, 8'h62);
    wr(2'd2, 8'hFF);
    wp_n = 1'b1;
    idle(3);
    rd_check(2'd0, 8'h00, "R8 protect wipes control");
    rd_check(2'd2, 8'h00, "R8 protect wipes blk");
    check("R8 erase off", {31'd0, erase_o}, 32'd0);
    wr(2'd0, 8'h40);
    rd_check(2'd0, 8'h00, "R3 swen blocked again");
    idle(2);
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule